// File: doc/BRIEF.md
# Bypassable Half-Band Decimator for Complex Samples

This block halves the sample rate of a complex baseband stream. Each accepted I/Q pair enters an eleven-deep delay line. On every second accepted pair, one filtered pair is emitted. The filter is a fixed, symmetric half-band FIR. Apart from the centre tap, every even-offset coefficient is zero, so only the centre tap and three mirrored pairs need multipliers. I and Q use identical, independent datapaths and share one valid strobe.

A bypass input turns the filter off at run time. While it is high, each accepted pair comes out one cycle later, unchanged, at the full input rate. Any change of the bypass level clears the delay line and restarts the decimation phase. The first filtered output after a mode change therefore always depends only on samples taken after the change.

Top module: `hbd_filter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is low and `out_i`/`out_q` are zero.
- R2: With bypass low, `out_valid` rises one cycle after every second accepted input and never after the other ones. The count starts at reset or at the last bypass change.
- R3: A filtered output equals the convolution of the last 11 accepted inputs x[n-k], k=0..10, scaled by 2^-15. The weights are 16384 at k=5, 9630 at k=4 and k=6, -1716 at k=2 and k=8, 278 at k=0 and k=10, and zero at every other k.
- R4: Rounding adds 2^14 to the sum and then shifts it arithmetically right by 15, so an exact half rounds towards plus infinity.
- R5: Results outside [-524288, 524287] saturate to the nearer limit.
- R6: With bypass high, every accepted pair appears on the outputs in the next cycle, bit for bit, with `out_valid` high.
- R7: A change of the bypass level zeroes the stored history and resets the decimation phase. The sample accepted in the cycle of the change counts as the first sample after the flush.
- R8: A cycle with `in_valid` low advances neither the history nor the phase, and gives `out_valid` low in the next cycle.
- R9: The I and Q outputs are computed independently, each from its own input rail only.
- R10: A constant input, once it fills the history, gives that same constant at the output (the weights sum to 32768).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bypass | input | 1 | 1 = pass samples through unfiltered at the full rate |
| in_valid | input | 1 | Input pair is present this cycle |
| in_i | input | 20 | In-phase input, signed |
| in_q | input | 20 | Quadrature input, signed |
| out_valid | output | 1 | Output pair is present this cycle |
| out_i | output | 20 | In-phase output, signed |
| out_q | output | 20 | Quadrature output, signed |

## Verification
The properties assume that `bypass` is a level the bench may move in any cycle, valid or idle. They also assume the output seen one cycle after an input was produced under the bypass level sampled together with that input. The stimulus keeps to this by driving all inputs at once, half a period away from the active edge. It flips bypass rarely, so long filtered runs also occur, and it mixes idle cycles and extreme values into random data. Directed frames follow a double toggle of bypass, which flushes the history, and set the window to exact impulses, half-way rounding cases, saturating patterns and a constant.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
    localparam int HBD_DATA_W = 20;
    localparam int HBD_COEF_W = 16;
    localparam int HBD_FRAC   = 15;
    localparam int HBD_HALF_K = 3;

    // weight of the mirrored pair at offset 2*m+1 from the centre tap
    function automatic int side_coef(input int m);
        case (m)
            0:       return 9630;
            1:       return -1716;
            2:       return 278;
            default: return 0;
        endcase
    endfunction

    function automatic int centre_coef(input int frac);
        return 1 << (frac - 1);
    endfunction
endpackage

// File: rtl/hbd_tapline.sv
module hbd_tapline #(
    parameter int DATA_W = 20,
    parameter int TAPS   = 11
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         shift,
    input  logic [DATA_W-1:0]            din,
    output logic [TAPS-1:0][DATA_W-1:0]  win
);
    logic [TAPS-2:0][DATA_W-1:0] hist_d, hist_q;

    always_comb begin
        win[0] = din;
        for (int k = 1; k < TAPS; k++) begin
            win[k] = flush ? '0 : hist_q[k-1];
        end
        hist_d = hist_q;
        if (flush) begin
            hist_d = '0;
        end
        if (shift) begin
            for (int k = 0; k < TAPS - 1; k++) begin
                hist_d[k] = win[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end
endmodule

// File: rtl/hbd_mac.sv
module hbd_mac
    import hbd_pkg::*;
#(
    parameter int DATA_W = 20,
    parameter int COEF_W = 16,
    parameter int FRAC   = 15,
    parameter int HALF_K = 3
) (
    input  logic [4*HALF_K-2:0][DATA_W-1:0] win,
    output logic [DATA_W-1:0]               y
);
    localparam int TAPS   = 4 * HALF_K - 1;
    localparam int CENTRE = 2 * HALF_K - 1;
    localparam int ACC_W  = DATA_W + COEF_W + 4;
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MINV = -ACC_W'(1 << (DATA_W - 1));
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1 << (FRAC - 1));
    localparam logic signed [ACC_W-1:0] CCOEF = ACC_W'(centre_coef(FRAC));

    logic signed [ACC_W-1:0] prod [HALF_K];
    logic signed [ACC_W-1:0] centre_term, acc, rnd, shifted;

    for (genvar m = 0; m < HALF_K; m++) begin : g_pair
        localparam int OFF = 2 * m + 1;
        localparam logic signed [ACC_W-1:0] COEF = ACC_W'(side_coef(m));
        logic signed [DATA_W:0]  pair;
        logic signed [ACC_W-1:0] pair_x;
        always_comb begin
            pair    = $signed({win[CENTRE-OFF][DATA_W-1], win[CENTRE-OFF]})
                    + $signed({win[CENTRE+OFF][DATA_W-1], win[CENTRE+OFF]});
            pair_x  = ACC_W'(pair);
            prod[m] = pair_x * COEF;
        end
    end

    always_comb begin
        centre_term = ACC_W'($signed(win[CENTRE])) * CCOEF;
        acc = centre_term;
        for (int m = 0; m < HALF_K; m++) begin
            acc = acc + prod[m];
        end
        rnd     = acc + HALF;
        shifted = rnd >>> FRAC;
        if (shifted > MAXV) begin
            y = MAXV[DATA_W-1:0];
        end else if (shifted < MINV) begin
            y = MINV[DATA_W-1:0];
        end else begin
            y = shifted[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/hbd_filter.sv
module hbd_filter
    import hbd_pkg::*;
#(
    parameter int DATA_W = HBD_DATA_W,
    parameter int COEF_W = HBD_COEF_W,
    parameter int FRAC   = HBD_FRAC,
    parameter int HALF_K = HBD_HALF_K
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bypass,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_i,
    input  logic [DATA_W-1:0] in_q,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_i,
    output logic [DATA_W-1:0] out_q
);
    localparam int TAPS  = 4 * HALF_K - 1;
    localparam int RAILS = 2;

    typedef struct packed {
        logic              byp;
        logic              phase;
        logic              vld;
        logic [DATA_W-1:0] oi;
        logic [DATA_W-1:0] oq;
    } state_t;

    state_t st_d, st_q;
    logic flush, shift, emit;
    logic [DATA_W-1:0] rail_in  [RAILS];
    logic [DATA_W-1:0] rail_out [RAILS];

    assign rail_in[0] = in_i;
    assign rail_in[1] = in_q;

    for (genvar r = 0; r < RAILS; r++) begin : g_rail
        logic [TAPS-1:0][DATA_W-1:0] win;
        hbd_tapline #(.DATA_W(DATA_W), .TAPS(TAPS)) u_line (
            .clk   (clk),
            .rst   (rst),
            .flush (flush),
            .shift (shift),
            .din   (rail_in[r]),
            .win   (win)
        );
        hbd_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC(FRAC), .HALF_K(HALF_K)) u_mac (
            .win (win),
            .y   (rail_out[r])
        );
    end

    always_comb begin
        flush = bypass != st_q.byp;
        shift = in_valid && !bypass;
        emit  = shift && !flush && st_q.phase;

        st_d     = st_q;
        st_d.byp = bypass;
        st_d.vld = 1'b0;
        if (flush) begin
            st_d.phase = shift;
        end else if (shift) begin
            st_d.phase = !st_q.phase;
        end

        if (in_valid && bypass) begin
            st_d.vld = 1'b1;
            st_d.oi  = in_i;
            st_d.oq  = in_q;
        end else if (emit) begin
            st_d.vld = 1'b1;
            st_d.oi  = rail_out[0];
            st_d.oq  = rail_out[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_i     = st_q.oi;
    assign out_q     = st_q.oq;
endmodule

// File: rtl/hbd_filter_chk.sv
module hbd_filter_chk #(
    parameter int DATA_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              bypass,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_i,
    input logic [DATA_W-1:0] in_q,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_i,
    input logic [DATA_W-1:0] out_q
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid);

    // R6
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bypass) |=> (out_valid && out_i == $past(in_i) && out_q == $past(in_q)));

    // R2
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(!bypass) && !bypass) |=> !out_valid);

    // R8
    idle_silent_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R7
    first_after_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !bypass && $past(bypass)) |=> !out_valid);
endmodule

bind hbd_filter hbd_filter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .bypass(bypass), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid),
    .out_i(out_i), .out_q(out_q)
);

// File: tb/hbd_filter_test.sv
module hbd_filter_test;
    localparam int W = 20;
    localparam longint MAXV = 524287;
    localparam longint MINV = -524288;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bypass = 1'b0;
    logic in_valid = 1'b0;
    logic [W-1:0] in_i = '0;
    logic [W-1:0] in_q = '0;
    logic out_valid;
    logic [W-1:0] out_i, out_q;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    longint hi [11];
    longint hq [11];
    bit m_byp, m_phase;
    bit exp_v;
    longint exp_i, exp_q;
    string exp_tag;
    longint last_i, last_q;

    hbd_filter uut (
        .clk(clk), .rst(rst), .bypass(bypass), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .out_valid(out_valid),
        .out_i(out_i), .out_q(out_q)
    );

    always #4 clk = ~clk;

    function automatic longint filt(input longint h [11]);
        longint acc, r;
        acc = 16384 * h[5] + 9630 * (h[4] + h[6]) - 1716 * (h[2] + h[8]) + 278 * (h[0] + h[10]);
        r = (acc + 16384) >>> 15;
        if (r > MAXV) r = MAXV;
        if (r < MINV) r = MINV;
        return r;
    endfunction

    function automatic longint sx(input logic [W-1:0] v);
        return longint'($signed(v));
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 11; k++) begin hi[k] = 0; hq[k] = 0; end
        m_byp = 0; m_phase = 0; exp_v = 0; exp_i = 0; exp_q = 0; exp_tag = "R8";
    endtask

    // compare the pending result, then drive one cycle of input
    task automatic step(input bit v, input bit b, input longint xi, input longint xq);
        @(negedge clk);
        check(out_valid == exp_v, exp_v ? "R2 valid" : "R8 valid", longint'(out_valid), longint'(exp_v));
        if (exp_v && out_valid) begin
            check(sx(out_i) == exp_i, {exp_tag, " I"}, sx(out_i), exp_i);
            check(sx(out_q) == exp_q, {exp_tag, " Q R9"}, sx(out_q), exp_q);
            last_i = sx(out_i); last_q = sx(out_q);
        end
        bypass = b; in_valid = v; in_i = W'(xi); in_q = W'(xq);
        if (b != m_byp) begin
            for (int k = 0; k < 11; k++) begin hi[k] = 0; hq[k] = 0; end
            m_phase = 0;
            m_byp = b;
        end
        exp_v = 0; exp_tag = "R8";
        if (v && b) begin
            exp_v = 1; exp_i = xi; exp_q = xq; exp_tag = "R6";
        end else if (v) begin
            for (int k = 10; k > 0; k--) begin hi[k] = hi[k-1]; hq[k] = hq[k-1]; end
            hi[0] = xi; hq[0] = xq;
            if (m_phase) begin
                exp_v = 1; exp_i = filt(hi); exp_q = filt(hq); exp_tag = "R3";
            end
            m_phase = !m_phase;
        end
    endtask

    task automatic flush_both();
        step(0, 1, 0, 0);
        step(0, 0, 0, 0);
    endtask

    // twelve samples after a flush; fr[0] is the oldest, the output lands on fr[11]
    task automatic frame(input longint fr [12], input longint fq [12]);
        flush_both();
        for (int s = 0; s < 12; s++) step(1, 0, fr[s], fq[s]);
        step(0, 0, 0, 0);
    endtask

    function automatic longint rnd_val();
        int sel;
        sel = $urandom_range(0, 9);
        if (sel == 0) return MAXV;
        if (sel == 1) return MINV;
        return sx(W'($urandom));
    endfunction

    initial begin
        longint fa [12];
        longint fb [12];
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) begin
            @(negedge clk);
            // R1
            check(out_valid == 0 && out_i == 0 && out_q == 0, "R1 reset", longint'(out_valid), 0);
        end
        rst = 1'b0;
        @(negedge clk);
        // R1 first cycle after reset
        check(out_valid == 0 && out_i == 0, "R1 after", longint'(out_valid), 0);

        // random stream with idle cycles (R8) and rare mode flips (R7)
        for (int c = 0; c < 4000; c++) begin
            bit b;
            b = m_byp;
            if ($urandom_range(0, 99) < 2) b = !b;
            step($urandom_range(0, 3) != 0, b, rnd_val(), rnd_val());
        end

        // R4 impulse at centre: 1 -> 1, -1 -> 0 (half rounds upwards); R7 history cleared
        for (int s = 0; s < 12; s++) begin fa[s] = 0; fb[s] = 0; end
        fa[6] = 1; fb[6] = -1;
        frame(fa, fb);
        check(last_i == 1, "R4 R7 +half", last_i, 1);
        check(last_q == 0, "R4 R9 -half", last_q, 0);

        // R5 saturation high on I, low on Q
        for (int s = 0; s < 12; s++) begin fa[s] = 0; fb[s] = 0; end
        for (int k = 0; k < 11; k++) begin
            longint sgn;
            sgn = (k == 2 || k == 8) ? -1 : ((k % 2 == 0) || k == 5 || k == 4 || k == 6) ? 1 : 0;
            if (k == 4 || k == 6 || k == 5 || k == 0 || k == 10) sgn = 1;
            fa[11-k] = (sgn > 0) ? MAXV : (sgn < 0) ? MINV : 0;
            fb[11-k] = (sgn > 0) ? MINV : (sgn < 0) ? MAXV : 0;
        end
        frame(fa, fb);
        check(last_i == MAXV, "R5 high", last_i, MAXV);
        check(last_q == MINV, "R5 R9 low", last_q, MINV);

        // R10 DC gain
        for (int s = 0; s < 12; s++) begin fa[s] = 12345; fb[s] = -777; end
        frame(fa, fb);
        check(last_i == 12345, "R10 dc", last_i, 12345);
        check(last_q == -777, "R10 R9 dc", last_q, -777);

        // R6 bypass burst
        for (int s = 0; s < 8; s++) step(1, 1, 1000 + s, -s);
        step(0, 1, 0, 0);
        check(last_i == 1007, "R6 last", last_i, 1007);

        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule